// File: doc/BRIEF.md
# Frame/Element Address Generator

This block produces the source and destination byte addresses for one channel of a memory-to-memory transfer engine. A transfer is a block made of frames, and each frame is made of elements of 1, 2 or 4 bytes. At launch the block captures two base addresses, an element count, a frame count, an element type code, and an addressing mode with an element index and a frame index for each side. After launch it presents the address pair of the current element. It moves to the next element on every accepted handshake (`step_i` while `elem_valid` is high). It marks the end of each frame, each packet and the whole block with single-cycle pulses.

Source and destination walk memory independently. Each side uses its own mode: fixed, stepping by the element size, stepping by a signed element index, or using a second signed index at frame ends. Both sides share one frame/element loop. That loop runs freely or is paced by one of several hardware request lines. One request opens a window for a single element, the rest of a frame, a whole block, or a packet of elements. The packet length is taken from one side's frame index. Memory access, burst building and byte swapping belong to the neighbouring blocks.

Top module: `xfer_addr_gen`

## Requirements
- R1: After reset `busy`, `elem_valid`, `frame_done`, `block_done` and `pkt_done` are 0, and both address outputs are 0.
- R2: A control write with `ctl_run`=1 while idle, and with both counts non-zero, raises `busy` on the next cycle with `src_addr`/`dst_addr` equal to the bases. All configuration inputs are captured at that write. Later changes to them, and further run writes while busy, have no effect on the running transfer.
- R3: A run write with an element count of 0 or a frame count of 0 is ignored, and `busy` stays 0.
- R4: Element type code 0 selects 1-byte elements and code 1 selects 2 bytes. Code 2 selects 4 bytes, and code 3 is treated as 4 bytes.
- R5: Mode code 0 (fixed) keeps the address. Code 1 adds the element size. Code 2 adds element size + element index − 1, with the index taken as a signed 16-bit value.
- R6: Mode code 3 behaves like code 2 inside a frame. On the step that leaves the last element of a frame, it instead adds element size + frame index − 1, with that index also signed.
- R7: The step that completes the last element of a frame gives a one-cycle `frame_done` on the next cycle. The step that completes the last element of the last frame also gives `block_done` on that cycle, and `busy` is 0 in the same cycle.
- R8: A control write with `ctl_run`=0 while busy clears `busy` on the next cycle and produces no `block_done`.
- R9: With sync select 0, `elem_valid` equals `busy`. With select n+1, only request line n opens a window. `elem_valid` rises the cycle after that line is seen high. Requests that arrive while a window is open are ignored.
- R10: One request opens a window for one element when no pacing flag is set. With the frame flag set, the window lasts to the end of the current frame. With the block flag set, it lasts to the end of the block. The packet flag takes precedence over the block flag, and the block flag over the frame flag.
- R11: With the packet flag set, a window covers a packet of elements. The packet length is the source frame index when `sync_on_src`=1 and the destination frame index otherwise. A window also ends at the block end, and each window end gives a one-cycle `pkt_done`.
- R12: `step_i` while `elem_valid` is 0 does not move the addresses or the loop position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_run | input | 1 | Run bit of the control write |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| elem_count | input | EW | Elements per frame |
| frame_count | input | FW | Frames per block |
| elem_type | input | 2 | Element size code |
| src_mode | input | 2 | Source addressing mode |
| dst_mode | input | 2 | Destination addressing mode |
| src_eidx | input | IW | Source element index (signed) |
| src_fidx | input | IW | Source frame index (signed) or packet length |
| dst_eidx | input | IW | Destination element index (signed) |
| dst_fidx | input | IW | Destination frame index (signed) or packet length |
| sync_sel | input | 7 | Request line select, 0 = free running |
| sync_frame | input | 1 | One request covers a frame |
| sync_block | input | 1 | One request covers the block |
| sync_pkt | input | 1 | One request covers a packet |
| sync_on_src | input | 1 | Packet length taken from source side |
| sync_req | input | NREQ | Hardware request lines |
| step_i | input | 1 | Element handshake |
| busy | output | 1 | Transfer running |
| elem_valid | output | 1 | Current element may move |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| frame_done | output | 1 | End-of-frame pulse |
| block_done | output | 1 | End-of-block pulse |
| pkt_done | output | 1 | End-of-packet pulse |

## Verification
On every cycle the assertions check the following. `elem_valid` and any open pacing window exist only while busy, and no window exists in free-running mode. A fixed-mode side and an idle handshake leave the addresses unchanged. The loop position stays inside the captured element count. `block_done` comes with `frame_done` and with `busy` low, and an abort is quiet. The actual address sequences under each mode and element size, including signed negative indices and the frame-end jump of the double-index mode, can only be shown by the bench's table of transfers. The same holds for the window lengths of each pacing choice, the selection of the packet-length source, and the capture of configuration at launch.

// File: rtl/xag_pkg.sv
package xag_pkg;

   typedef enum logic [1:0] {
      AM_FIXED = 2'd0,
      AM_STEP  = 2'd1,
      AM_SKIP  = 2'd2,
      AM_GRID  = 2'd3
   } addr_mode_e;

   typedef enum logic [1:0] {
      PACE_ELEM  = 2'd0,
      PACE_FRAME = 2'd1,
      PACE_BLOCK = 2'd2,
      PACE_PKT   = 2'd3
   } pace_e;

   localparam int SEL_W = 7;

   function automatic logic [2:0] type_bytes(input logic [1:0] code);
      case (code)
         2'd0:    type_bytes = 3'd1;
         2'd1:    type_bytes = 3'd2;
         default: type_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/xag_side.sv
module xag_side
   import xag_pkg::*;
#(
   parameter int AW = 32,
   parameter int IW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic [1:0]    mode,
   input  logic [2:0]    ebytes,
   input  logic [IW-1:0] eidx,
   input  logic [IW-1:0] fidx,
   input  logic          adv,
   input  logic          frame_end,
   output logic [AW-1:0] addr
);

   addr_mode_e    mode_q;
   logic [2:0]    ebytes_q;
   logic [IW-1:0] eidx_q;
   logic [IW-1:0] fidx_q;
   logic [AW-1:0] e_ext;
   logic [AW-1:0] f_ext;
   logic [AW-1:0] es;
   logic [AW-1:0] inc;

   generate
      if (AW > IW) begin : g_sext
         assign e_ext = {{(AW-IW){eidx_q[IW-1]}}, eidx_q};
         assign f_ext = {{(AW-IW){fidx_q[IW-1]}}, fidx_q};
      end else begin : g_trunc
         assign e_ext = eidx_q[AW-1:0];
         assign f_ext = fidx_q[AW-1:0];
      end
   endgenerate

   assign es = AW'(ebytes_q);

   always_comb begin
      case (mode_q)
         AM_FIXED: inc = '0;
         AM_STEP:  inc = es;
         AM_SKIP:  inc = es + e_ext - AW'(1);
         default:  inc = frame_end ? (es + f_ext - AW'(1)) : (es + e_ext - AW'(1));
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= AM_FIXED;
         ebytes_q <= 3'd1;
         eidx_q   <= '0;
         fidx_q   <= '0;
         addr     <= '0;
      end else if (load) begin
         mode_q   <= addr_mode_e'(mode);
         ebytes_q <= ebytes;
         eidx_q   <= eidx;
         fidx_q   <= fidx;
         addr     <= base;
      end else if (adv) begin
         addr     <= addr + inc;
      end
   end

   a_r5_fixed_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == AM_FIXED && !load) |=> $stable(addr));

   a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !load) |=> $stable(addr));

endmodule

// File: rtl/xag_loop.sv
module xag_loop #(
   parameter int EW = 24,
   parameter int FW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          busy,
   input  logic [EW-1:0] ecnt,
   input  logic [FW-1:0] fcnt,
   input  logic          adv,
   output logic          last_elem,
   output logic          block_end
);

   logic [EW-1:0] ecnt_q;
   logic [FW-1:0] fcnt_q;
   logic [EW-1:0] epos;
   logic [FW-1:0] fpos;
   logic          last_frame;

   assign last_elem  = (epos == ecnt_q - EW'(1));
   assign last_frame = (fpos == fcnt_q - FW'(1));
   assign block_end  = last_elem && last_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt_q <= '0;
         fcnt_q <= '0;
         epos   <= '0;
         fpos   <= '0;
      end else if (load) begin
         ecnt_q <= ecnt;
         fcnt_q <= fcnt;
         epos   <= '0;
         fpos   <= '0;
      end else if (adv) begin
         if (last_elem) begin
            epos <= '0;
            fpos <= last_frame ? '0 : fpos + FW'(1);
         end else begin
            epos <= epos + EW'(1);
         end
      end
   end

   a_r7_elem_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (epos < ecnt_q && fpos < fcnt_q));

endmodule

// File: rtl/xag_pace.sv
module xag_pace
   import xag_pkg::*;
#(
   parameter int IW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          kill,
   input  logic          busy,
   input  logic          unsynced,
   input  logic          req_hit,
   input  logic [1:0]    pace_in,
   input  logic [IW-1:0] pkt_len,
   input  logic          adv,
   input  logic          last_elem,
   input  logic          block_end,
   output logic          win_open,
   output logic          pkt_close,
   output logic          pkt_mode
);

   pace_e         pace_q;
   logic [IW-1:0] pkt_len_q;
   logic [IW-1:0] pkt_pos;
   logic          win_close;

   assign pkt_mode  = (pace_q == PACE_PKT);
   assign pkt_close = (({1'b0, pkt_pos} + (IW+1)'(1)) >= {1'b0, pkt_len_q}) || block_end;

   always_comb begin
      case (pace_q)
         PACE_ELEM:  win_close = 1'b1;
         PACE_FRAME: win_close = last_elem;
         PACE_BLOCK: win_close = block_end;
         default:    win_close = pkt_close;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pace_q    <= PACE_ELEM;
         pkt_len_q <= '0;
         pkt_pos   <= '0;
         win_open  <= 1'b0;
      end else if (load) begin
         pace_q    <= pace_e'(pace_in);
         pkt_len_q <= pkt_len;
         pkt_pos   <= '0;
         win_open  <= 1'b0;
      end else if (kill) begin
         win_open  <= 1'b0;
      end else begin
         if (adv && pkt_mode)
            pkt_pos <= pkt_close ? '0 : pkt_pos + IW'(1);
         if (win_open && adv && win_close)
            win_open <= 1'b0;
         else if (!win_open && busy && !unsynced && req_hit)
            win_open <= 1'b1;
      end
   end

   a_r9_window_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      win_open |-> busy);

   a_r9_free_run_no_window: assert property (@(posedge clk) disable iff (!rst_n)
      unsynced |-> !win_open);

endmodule

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen
   import xag_pkg::*;
#(
   parameter int AW   = 32,
   parameter int EW   = 24,
   parameter int FW   = 16,
   parameter int IW   = 16,
   parameter int NREQ = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_wr,
   input  logic            ctl_run,
   input  logic [AW-1:0]   src_base,
   input  logic [AW-1:0]   dst_base,
   input  logic [EW-1:0]   elem_count,
   input  logic [FW-1:0]   frame_count,
   input  logic [1:0]      elem_type,
   input  logic [1:0]      src_mode,
   input  logic [1:0]      dst_mode,
   input  logic [IW-1:0]   src_eidx,
   input  logic [IW-1:0]   src_fidx,
   input  logic [IW-1:0]   dst_eidx,
   input  logic [IW-1:0]   dst_fidx,
   input  logic [6:0]      sync_sel,
   input  logic            sync_frame,
   input  logic            sync_block,
   input  logic            sync_pkt,
   input  logic            sync_on_src,
   input  logic [NREQ-1:0] sync_req,
   input  logic            step_i,
   output logic            busy,
   output logic            elem_valid,
   output logic [AW-1:0]   src_addr,
   output logic [AW-1:0]   dst_addr,
   output logic            frame_done,
   output logic            block_done,
   output logic            pkt_done
);

   localparam int SIDES = 2;

   generate
      if (NREQ < 1 || NREQ > 127) begin : g_bad_nreq
         $error("NREQ must lie in 1..127");
      end
      if (AW < 8 || IW < 2 || EW < 1 || FW < 1) begin : g_bad_width
         $error("address, index or count width too small");
      end
   endgenerate

   logic             start;
   logic             abort;
   logic             adv;
   logic             kill;
   logic             last_elem;
   logic             block_end;
   logic             win_open;
   logic             pkt_close;
   logic             pkt_mode;
   logic             req_hit;
   logic [SEL_W-1:0] sel_q;
   logic             unsynced;
   logic [1:0]       pace_d;
   logic [2:0]       ebytes;

   logic [AW-1:0]    side_base [SIDES];
   logic [1:0]       side_mode [SIDES];
   logic [IW-1:0]    side_eidx [SIDES];
   logic [IW-1:0]    side_fidx [SIDES];
   logic [AW-1:0]    side_addr [SIDES];

   assign start = ctl_wr && ctl_run && !busy && (elem_count != '0) && (frame_count != '0);
   assign abort = ctl_wr && !ctl_run && busy;
   assign elem_valid = busy && (unsynced || win_open);
   assign adv   = step_i && elem_valid;
   assign kill  = abort || (adv && block_end);
   assign unsynced = (sel_q == '0);
   assign ebytes = type_bytes(elem_type);

   always_comb begin
      if (sync_pkt)        pace_d = PACE_PKT;
      else if (sync_block) pace_d = PACE_BLOCK;
      else if (sync_frame) pace_d = PACE_FRAME;
      else                 pace_d = PACE_ELEM;
   end

   always_comb begin
      req_hit = 1'b0;
      for (int i = 0; i < NREQ; i++)
         if (sel_q == SEL_W'(i + 1)) req_hit = sync_req[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         sel_q      <= '0;
         frame_done <= 1'b0;
         block_done <= 1'b0;
         pkt_done   <= 1'b0;
      end else begin
         frame_done <= adv && last_elem && !abort;
         block_done <= adv && block_end && !abort;
         pkt_done   <= adv && pkt_mode && pkt_close && !abort;
         if (start) begin
            busy  <= 1'b1;
            sel_q <= sync_sel;
         end else if (kill) begin
            busy  <= 1'b0;
         end
      end
   end

   assign side_base[0] = src_base;
   assign side_mode[0] = src_mode;
   assign side_eidx[0] = src_eidx;
   assign side_fidx[0] = src_fidx;
   assign side_base[1] = dst_base;
   assign side_mode[1] = dst_mode;
   assign side_eidx[1] = dst_eidx;
   assign side_fidx[1] = dst_fidx;
   assign src_addr = side_addr[0];
   assign dst_addr = side_addr[1];

   generate
      for (genvar s = 0; s < SIDES; s++) begin : g_side
         xag_side #(.AW(AW), .IW(IW)) u_side (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (start),
            .base      (side_base[s]),
            .mode      (side_mode[s]),
            .ebytes    (ebytes),
            .eidx      (side_eidx[s]),
            .fidx      (side_fidx[s]),
            .adv       (adv),
            .frame_end (last_elem),
            .addr      (side_addr[s])
         );
      end
   endgenerate

   xag_loop #(.EW(EW), .FW(FW)) u_loop (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .busy      (busy),
      .ecnt      (elem_count),
      .fcnt      (frame_count),
      .adv       (adv),
      .last_elem (last_elem),
      .block_end (block_end)
   );

   xag_pace #(.IW(IW)) u_pace (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .kill      (kill),
      .busy      (busy),
      .unsynced  (unsynced),
      .req_hit   (req_hit),
      .pace_in   (pace_d),
      .pkt_len   (sync_on_src ? src_fidx : dst_fidx),
      .adv       (adv),
      .last_elem (last_elem),
      .block_end (block_end),
      .win_open  (win_open),
      .pkt_close (pkt_close),
      .pkt_mode  (pkt_mode)
   );

   a_r9_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      elem_valid |-> busy);

   a_r7_block_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
      block_done |-> (frame_done && !busy));

   a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_run && busy) |=> (!busy && !block_done));

endmodule

// File: tb/xfer_addr_gen_tb.sv
module xfer_addr_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NREQ = 8;
   localparam int WATCHDOG = 20000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ctl_wr = 1'b0;
   logic            ctl_run = 1'b0;
   logic [31:0]     src_base = '0;
   logic [31:0]     dst_base = '0;
   logic [23:0]     elem_count = '0;
   logic [15:0]     frame_count = '0;
   logic [1:0]      elem_type = '0;
   logic [1:0]      src_mode = '0;
   logic [1:0]      dst_mode = '0;
   logic [15:0]     src_eidx = '0;
   logic [15:0]     src_fidx = '0;
   logic [15:0]     dst_eidx = '0;
   logic [15:0]     dst_fidx = '0;
   logic [6:0]      sync_sel = '0;
   logic            sync_frame = 1'b0;
   logic            sync_block = 1'b0;
   logic            sync_pkt = 1'b0;
   logic            sync_on_src = 1'b0;
   logic [NREQ-1:0] sync_req = '0;
   logic            step_i = 1'b0;
   logic            busy;
   logic            elem_valid;
   logic [31:0]     src_addr;
   logic [31:0]     dst_addr;
   logic            frame_done;
   logic            block_done;
   logic            pkt_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xfer_addr_gen #(.NREQ(NREQ)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_run(ctl_run),
      .src_base(src_base), .dst_base(dst_base),
      .elem_count(elem_count), .frame_count(frame_count),
      .elem_type(elem_type), .src_mode(src_mode), .dst_mode(dst_mode),
      .src_eidx(src_eidx), .src_fidx(src_fidx),
      .dst_eidx(dst_eidx), .dst_fidx(dst_fidx),
      .sync_sel(sync_sel), .sync_frame(sync_frame), .sync_block(sync_block),
      .sync_pkt(sync_pkt), .sync_on_src(sync_on_src), .sync_req(sync_req),
      .step_i(step_i), .busy(busy), .elem_valid(elem_valid),
      .src_addr(src_addr), .dst_addr(dst_addr),
      .frame_done(frame_done), .block_done(block_done), .pkt_done(pkt_done)
   );

   typedef struct packed {
      logic [1:0]  ty;
      logic [1:0]  sm;
      logic [1:0]  dm;
      logic [15:0] se;
      logic [15:0] sf;
      logic [15:0] de;
      logic [15:0] df;
      logic [23:0] ec;
      logic [15:0] fc;
      logic [31:0] sb;
      logic [31:0] db;
      logic [31:0] exp_s;
      logic [31:0] exp_d;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VEC [NVEC] = '{
      '{2'd2, 2'd1, 2'd0, 16'd0, 16'd0, 16'd0, 16'd0, 24'd4, 16'd2,
        32'h1000, 32'h2000, 32'h101C, 32'h2000},
      '{2'd0, 2'd2, 2'd1, 16'd3, 16'd0, 16'd0, 16'd0, 24'd3, 16'd2,
        32'h0100, 32'h0300, 32'h010F, 32'h0305},
      '{2'd1, 2'd3, 2'd3, 16'd2, 16'd10, 16'd1, 16'hFFFD, 24'd3, 16'd3,
        32'h0400, 32'h0800, 32'h0428, 32'h0808},
      '{2'd2, 2'd0, 2'd2, 16'd0, 16'd0, 16'hFFF9, 16'd0, 24'd5, 16'd1,
        32'h0050, 32'h1000, 32'h0050, 32'h0FF0},
      '{2'd1, 2'd1, 2'd1, 16'd0, 16'd0, 16'd0, 16'd0, 24'd1, 16'd1,
        32'h0010, 32'h0020, 32'h0010, 32'h0020},
      '{2'd3, 2'd1, 2'd0, 16'd0, 16'd0, 16'd0, 16'd0, 24'd3, 16'd1,
        32'h0000, 32'h0040, 32'h0008, 32'h0040}
   };

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic ctl_write(input logic run);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_run = run;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic pulse_req(input int line);
      @(negedge clk);
      sync_req = NREQ'(1) << line;
      @(negedge clk);
      sync_req = '0;
   endtask

   // step continuously while the window is open; returns number of steps
   task automatic drain(output int n);
      n = 0;
      while (elem_valid && n < 1000) begin
         step_i = 1'b1;
         @(negedge clk);
         step_i = 1'b0;
         n++;
      end
   endtask

   task automatic set_sync(input logic [6:0] sel, input logic fr, input logic bl,
                           input logic pk, input logic onsrc);
      sync_sel = sel;
      sync_frame = fr;
      sync_block = bl;
      sync_pkt = pk;
      sync_on_src = onsrc;
   endtask

   task automatic plain_cfg(input logic [23:0] ec, input logic [15:0] fc);
      elem_type = 2'd2;
      src_mode = 2'd1;
      dst_mode = 2'd1;
      src_base = 32'h0;
      dst_base = 32'h0;
      elem_count = ec;
      frame_count = fc;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
         summary();
         $finish;
      end
   end

   initial begin : main
      int n;
      int frames;
      int guard;
      logic [31:0] first_s;
      logic [31:0] first_d;
      logic [31:0] last_s;
      logic [31:0] last_d;
      logic        saw_blk;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(!busy && !elem_valid && !frame_done && !block_done && !pkt_done, "R1 flags",
            {busy, elem_valid, frame_done, block_done, pkt_done}, 0);
      check(src_addr == 0 && dst_addr == 0, "R1 addresses", src_addr | dst_addr, 0);

      // table of free-running transfers: R4 R5 R6 R7
      for (int v = 0; v < NVEC; v++) begin
         elem_type = VEC[v].ty;
         src_mode = VEC[v].sm;
         dst_mode = VEC[v].dm;
         src_eidx = VEC[v].se;
         src_fidx = VEC[v].sf;
         dst_eidx = VEC[v].de;
         dst_fidx = VEC[v].df;
         elem_count = VEC[v].ec;
         frame_count = VEC[v].fc;
         src_base = VEC[v].sb;
         dst_base = VEC[v].db;
         set_sync(7'd0, 1'b0, 1'b0, 1'b0, 1'b0);
         ctl_write(1'b1);
         n = 0;
         frames = 0;
         guard = 0;
         first_s = '0;
         first_d = '0;
         last_s = '0;
         last_d = '0;
         while (!block_done && guard < 2000) begin
            if (frame_done) frames++;
            if (elem_valid) begin
               if (n == 0) begin
                  first_s = src_addr;
                  first_d = dst_addr;
               end
               last_s = src_addr;
               last_d = dst_addr;
               step_i = 1'b1;
               n++;
            end else begin
               step_i = 1'b0;
            end
            @(negedge clk);
            guard++;
         end
         step_i = 1'b0;
         saw_blk = block_done;
         if (frame_done) frames++;
         check(first_s == VEC[v].sb && first_d == VEC[v].db, "R2 first address = base",
               {first_s, first_d}, {VEC[v].sb, VEC[v].db});
         check(last_s == VEC[v].exp_s, "R4/R5/R6 last source address", last_s, VEC[v].exp_s);
         check(last_d == VEC[v].exp_d, "R4/R5/R6 last destination address", last_d, VEC[v].exp_d);
         check(n == int'(VEC[v].ec) * int'(VEC[v].fc), "R7 element total", n,
               int'(VEC[v].ec) * int'(VEC[v].fc));
         check(frames == int'(VEC[v].fc), "R7 frame pulses", frames, VEC[v].fc);
         check(saw_blk && !busy, "R7 block end", {saw_blk, busy}, 2'b10);
         @(negedge clk);
      end

      // R3: zero counts ignored
      plain_cfg(24'd0, 16'd2);
      ctl_write(1'b1);
      check(!busy, "R3 zero element count", busy, 0);
      plain_cfg(24'd3, 16'd0);
      ctl_write(1'b1);
      check(!busy, "R3 zero frame count", busy, 0);

      // R2: config captured at launch, run write while busy ignored
      plain_cfg(24'd8, 16'd1);
      src_base = 32'h1000;
      dst_base = 32'h3000;
      set_sync(7'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      ctl_write(1'b1);
      check(busy && src_addr == 32'h1000 && dst_addr == 32'h3000, "R2 launch",
            src_addr, 32'h1000);
      step_i = 1'b1;
      @(negedge clk);
      step_i = 1'b0;
      src_base = 32'h5000;
      src_mode = 2'd0;
      elem_type = 2'd0;
      ctl_write(1'b1);
      step_i = 1'b1;
      @(negedge clk);
      step_i = 1'b0;
      check(busy && src_addr == 32'h1008, "R2 config change ignored", src_addr, 32'h1008);

      // R8: abort
      ctl_write(1'b0);
      check(!busy && !block_done && !elem_valid, "R8 abort", {busy, block_done, elem_valid}, 0);

      // R9 R10 R12: element pacing on request line 2 (select 3)
      plain_cfg(24'd2, 16'd1);
      src_base = 32'h200;
      set_sync(7'd3, 1'b0, 1'b0, 1'b0, 1'b0);
      ctl_write(1'b1);
      @(negedge clk);
      check(busy && !elem_valid, "R9 waits for request", elem_valid, 0);
      step_i = 1'b1;
      @(negedge clk);
      step_i = 1'b0;
      check(src_addr == 32'h200, "R12 step without valid ignored", src_addr, 32'h200);
      pulse_req(0);
      check(!elem_valid, "R9 wrong line ignored", elem_valid, 0);
      pulse_req(2);
      check(elem_valid, "R9 selected line opens window", elem_valid, 1);
      drain(n);
      check(n == 1 && src_addr == 32'h204, "R10 one element per request", n, 1);
      pulse_req(2);
      drain(n);
      check(n == 1 && block_done && !busy, "R10 element pacing block end", n, 1);

      // R10 frame pacing
      plain_cfg(24'd3, 16'd2);
      set_sync(7'd1, 1'b1, 1'b0, 1'b0, 1'b0);
      ctl_write(1'b1);
      pulse_req(0);
      drain(n);
      check(n == 3 && frame_done && busy, "R10 frame window", n, 3);
      pulse_req(0);
      drain(n);
      check(n == 3 && block_done, "R10 second frame window", n, 3);

      // R10 block pacing (frame flag also set: block wins)
      plain_cfg(24'd2, 16'd2);
      set_sync(7'd1, 1'b1, 1'b1, 1'b0, 1'b0);
      ctl_write(1'b1);
      pulse_req(0);
      drain(n);
      check(n == 4 && block_done && !busy, "R10 block window", n, 4);

      // R11 packet pacing, length from source frame index
      plain_cfg(24'd5, 16'd1);
      src_fidx = 16'd3;
      dst_fidx = 16'd2;
      set_sync(7'd2, 1'b0, 1'b1, 1'b1, 1'b1);
      ctl_write(1'b1);
      pulse_req(1);
      drain(n);
      check(n == 3 && pkt_done, "R11 source packet length", n, 3);
      pulse_req(1);
      drain(n);
      check(n == 2 && pkt_done && block_done, "R11 packet cut at block end", n, 2);

      // R11 packet length from destination frame index
      plain_cfg(24'd5, 16'd1);
      src_fidx = 16'd3;
      dst_fidx = 16'd2;
      set_sync(7'd2, 1'b0, 1'b0, 1'b1, 1'b0);
      ctl_write(1'b1);
      pulse_req(1);
      drain(n);
      check(n == 2 && pkt_done && busy, "R11 destination packet length", n, 2);
      ctl_write(1'b0);
      check(!busy, "R8 abort after packet", busy, 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule